// File: doc/BRIEF.md
# Carry-Less Multiply-Accumulate Unit

This unit forms the polynomial product over GF(2) of two 32-bit operands. Partial products are merged with XOR in place of addition, so no carries propagate. A start pulse captures both operands and a mode select. The unit then walks the multiplier from its least significant bit upward, one bit per cycle. Whenever the current multiplier bit is set, it XORs a 64-bit shifted copy of the multiplicand into a running result.

When the walk finishes, the 64-bit result goes into a result register pair, HI for the upper half and LO for the lower half. In overwrite mode the result replaces the pair and the extension register ACX is cleared. In accumulate mode the result is XOR-merged into the pair and ACX keeps its value. ACX is never computed here. It is only cleared, by reset or by an overwrite.

Top module: `clmul_acc`

## Requirements
- R1: While `rst` is high at a clock edge, the unit clears `hi`, `lo`, `acx`, `busy`, `done` and all internal state, so all of them read zero after that edge.
- R2: With `accum` = 0 at start, the unit computes the product P, where bit k of P is the XOR over all i+j=k of `op_a[i] & op_b[j]`. When `done` is high, `lo` equals P[31:0] and `hi` equals P[63:32].
- R3: An overwrite operation (`accum` = 0) sets `acx` to zero in the cycle `done` is high.
- R4: With `accum` = 1 at start, `lo` becomes old `lo` XOR P[31:0] and `hi` becomes old `hi` XOR P[63:32]. `acx` stays unchanged.
- R5: A start pulse accepted at one clock edge raises `busy` after that edge. `busy` then stays high for exactly 32 cycles. In the following cycle `busy` is low and `done` is high for exactly one cycle.
- R6: The unit captures `op_a`, `op_b` and `accum` at the accepted start edge. Changes to these inputs while `busy` is high do not affect the result.
- R7: The unit ignores a start pulse that arrives while `busy` is high. It starts no new operation, and the running operation keeps its operands and its 32-cycle length.
- R8: `hi`, `lo` and `acx` change only in the cycle where `done` is high, so partial results never appear on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, accepted only while idle |
| accum | input | 1 | Mode: 0 overwrite, 1 XOR-accumulate |
| op_a | input | 32 | Multiplier operand |
| op_b | input | 32 | Multiplicand operand |
| busy | output | 1 | High while an operation runs |
| done | output | 1 | One-cycle pulse when HI/LO are updated |
| hi | output | 32 | Upper half of the result pair |
| lo | output | 32 | Lower half of the result pair |
| acx | output | 8 | Extension register, cleared by overwrite |

## Verification
The hardest case to reach from the ports is a second start pulse, carrying different operands and the opposite mode, that arrives in the middle of a running operation. The stimulus produces it with a pulse injected partway through the busy window. The operand and mode inputs are also scrambled on every busy cycle. The result must still match the first operands, and the busy window must still last 32 cycles. Accumulate chains over random operands make the old HI/LO contents matter, and repeating the same product cancels the pair back to its earlier value.

// File: rtl/clmul_acc.sv
module clmul_acc #(
  parameter int W     = 32,
  parameter int ACX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             accum,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  output logic             busy,
  output logic             done,
  output logic [W-1:0]     hi,
  output logic [W-1:0]     lo,
  output logic [ACX_W-1:0] acx
);
  localparam int CW = $clog2(W);

  logic [CW-1:0]  cnt;
  logic [W-1:0]   mplr;
  logic [2*W-1:0] mcand, part, part_nx;
  logic           mode;
  logic           last;

  assign part_nx = part ^ (mplr[0] ? mcand : '0);
  assign last    = (cnt == CW'(W-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      hi    <= '0;
      lo    <= '0;
      acx   <= '0;
      cnt   <= '0;
      mplr  <= '0;
      mcand <= '0;
      part  <= '0;
      mode  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          cnt   <= '0;
          mplr  <= op_a;
          mcand <= {{W{1'b0}}, op_b};
          part  <= '0;
          mode  <= accum;
        end
      end else begin
        part  <= part_nx;
        mplr  <= mplr >> 1;
        mcand <= mcand << 1;
        cnt   <= cnt + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (mode) begin
            lo <= lo ^ part_nx[W-1:0];
            hi <= hi ^ part_nx[2*W-1:W];
          end else begin
            lo  <= part_nx[W-1:0];
            hi  <= part_nx[2*W-1:W];
            acx <= '0;
          end
        end
      end
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                     // R5
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);                                               // R5
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));                                       // R7
  AST_PAIR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!done && $past(rst) == 1'b0) |-> ($stable(hi) && $stable(lo) && $stable(acx))); // R8
endmodule

// File: tb/test_clmul_acc.sv
module test_clmul_acc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        accum = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        busy, done;
  logic [31:0] hi, lo;
  logic [7:0]  acx;

  int checks = 0, errors = 0;
  logic [31:0] m_hi = '0, m_lo = '0;
  logic [7:0]  m_acx = '0;

  clmul_acc i_clmul_acc (.clk(clk), .rst(rst), .start(start), .accum(accum),
    .op_a(op_a), .op_b(op_b), .busy(busy), .done(done), .hi(hi), .lo(lo), .acx(acx));

  always #5 clk = ~clk;

  function automatic logic [63:0] clmul(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 32; i++)
      if (a[i]) r ^= ({32'b0, b} << i);
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic m, input bit disturb);
    logic [63:0] p = clmul(a, b);
    int n;
    @(negedge clk);
    op_a = a; op_b = b; accum = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R5 busy after start", {63'b0, busy}, 64'd1);
    n = 1;
    for (int k = 0; k < 40; k++) begin
      if (disturb) begin
        op_a = $urandom; op_b = $urandom; accum = ~m;
        start = (k == 5);
      end
      @(negedge clk);
      if (done) break;
      n++;
      chk("R8 pair held while busy", {hi, lo}, {m_hi, m_lo});
    end
    start = 1'b0;
    chk(disturb ? "R7 busy length with extra start" : "R5 busy length", n, 32);
    chk("R5 done with busy low", {62'b0, done, busy}, 64'd2);
    if (m) begin m_hi ^= p[63:32]; m_lo ^= p[31:0]; end
    else begin m_hi = p[63:32]; m_lo = p[31:0]; m_acx = '0; end
    chk(m ? "R4 accumulate result" : (disturb ? "R6 captured operands" : "R2 overwrite result"),
        {hi, lo}, {m_hi, m_lo});
    chk(m ? "R4 acx unchanged" : "R3 acx cleared", {56'b0, acx}, {56'b0, m_acx});
    @(negedge clk);
    chk("R5 done single cycle", {63'b0, done}, 64'd0);
    chk("R7 no new operation", {63'b0, busy}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7031));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset state", {hi, lo}, 64'd0);
    chk("R1 reset flags", {54'b0, acx, busy, done}, 64'd0);
    run(32'h0, 32'h0, 1'b0, 1'b0);
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
    run(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0);
    run(32'h1, 32'hDEAD_BEEF, 1'b1, 1'b0);
    run(32'h1, 32'hDEAD_BEEF, 1'b1, 1'b0);
    run(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 1'b1);
    for (int t = 0; t < 40; t++)
      run($urandom, $urandom, 1'($urandom_range(0, 1)), t % 7 == 3);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset after use", {54'b0, acx, busy, done}, 64'd0);
    chk("R1 reset clears pair", {hi, lo}, 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule